// File: doc/BRIEF.md
# Dual-Requester GPIO Register Bank

This block is the register front end of a 30-pin general-purpose I/O bank in a system with two processor cores. Each core has its own simple 32-bit register port. Through that port a core can read the synchronized pin levels. It can read and write an output-value register and an output-enable register. It can also read a core-identifier word, whose value depends on which port the read arrives on.

Each of the two writable registers has three extra write addresses that set, clear or toggle only the bits written as 1. Software can change single pins with one bus write and no read-modify-write sequence, so the two cores never race on a shared register. When both cores update the same register in the same cycle, the two updates are composed in a fixed order and applied together.

The bank drives a per-pin output value and a per-pin drive enable towards the pads. A pin whose enable bit is clear is left undriven.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output and enable registers are zero, `padOut` and `padOe` are all zero, and both read-data words are zero.
- R2: A write to byte address 0x10 (output) or 0x20 (enable) replaces that register with bits 29..0 of the write data. Reading the same address returns the register in bits 29..0. Bits 31..30 of any read word are zero, and write-data bits 31..30 are discarded.
- R3: A write to 0x14 ORs the write data into the output register. A write to 0x24 ORs it into the enable register.
- R4: A write to 0x18 (output) or 0x28 (enable) clears the bits written as 1. A write to 0x1C (output) or 0x2C (enable) inverts the bits written as 1. Bits written as 0 keep their value.
- R5: A read of address 0x00 returns 0 on core port 0 and 1 on core port 1, including when both ports read it in the same cycle.
- R6: `padIn` passes through two register stages before it is visible at address 0x04. A read sampled on the second rising edge after a pad change returns the old level. A read sampled on the third edge returns the new level.
- R7: When both ports write the same register in one cycle, the result is port 1's operation applied to the result of port 0's operation, and it appears after that single edge. Writes from the two ports to different registers in one cycle both take effect.
- R8: A read of an alias address (0x14, 0x18, 0x1C, 0x24, 0x28, 0x2C) returns the current value of the register that the alias updates.
- R9: `padOe[i]` equals enable bit i. `padOut[i]` equals output bit i while enable bit i is 1, and is 0 while the pin is undriven.
- R10: Read data is registered. It appears on the port's read-data word in the cycle after the read request, and it holds until that port's next read. A read that coincides with a write returns the value from before the write. Reads of addresses 0x08, 0x0C, anything above 0x2C, or any address whose two low bits are not zero return zero.
- R11: Writes to 0x00, 0x04, 0x08, 0x0C, to addresses above 0x2C, or to addresses whose two low bits are not zero change neither register nor any pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 2 | Per-port request strobe (bit c belongs to core c) |
| busWr | input | 2 | Per-port write (1) or read (0) |
| busAddr | input | 12 | Per-port byte address, 6 bits per port, port c at bits 6c+5..6c |
| busWdata | input | 64 | Per-port write data, 32 bits per port |
| busRdata | output | 64 | Per-port registered read data, 32 bits per port |
| padIn | input | 30 | Asynchronous pin levels |
| padOut | output | 30 | Pin output values |
| padOe | output | 30 | Pin drive enables (0 = undriven) |

## Verification
The checker watches every cycle for four things. A pin must never drive without its enable. The unused top bits of the read words must stay zero. A core-identifier read must return the requesting port's number. A lone set, clear or toggle of the enable register must touch exactly the bits written. It also checks that the pads hold still across any cycle without a write to either register, and that read data holds between reads.

Other behaviours need the bench's scenarios. These are the ordered composition when both cores hit the same register in one cycle, and the read that returns the value from before a coincident write. They also include the exact two-stage input latency and the alias readbacks. The rejected writes to read-only, reserved and misaligned addresses are also shown by the bench, which compares readbacks and pad outputs against its own model after each operation.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W = 32;

  // Register update kinds produced by the decoder
  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_SET,
    OP_CLEAR,
    OP_FLIP
  } regOp_e;

  // Read data sources
  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_CORE_ID,
    SRC_PINS,
    SRC_OUT,
    SRC_OE
  } readSrc_e;

  // Strobes handed from control to datapath, one set per core port
  typedef struct packed {
    regOp_e   outOp;
    regOp_e   oeOp;
    logic     rdEn;
    readSrc_e rdSrc;
  } coreStrobe_t;

  // Word groups inside the register window (address bits above the alias bits)
  localparam int GROUP_MISC = 0;  // core id, pins, two reserved words
  localparam int GROUP_OUT  = 1;  // output value and its three aliases
  localparam int GROUP_OE   = 2;  // output enable and its three aliases

  // Update operation applied to one register value
  function automatic logic [BUS_W-1:0] applyOp(regOp_e op, logic [BUS_W-1:0] cur,
                                               logic [BUS_W-1:0] data);
    logic [BUS_W-1:0] res;
    case (op)
      OP_WRITE: res = data;
      OP_SET:   res = cur | data;
      OP_CLEAR: res = cur & ~data;
      OP_FLIP:  res = cur ^ data;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 6
) (
  input  logic [NUM_CORES-1:0]        busSel,
  input  logic [NUM_CORES-1:0]        busWr,
  input  logic [NUM_CORES*ADDR_W-1:0] busAddr,
  output coreStrobe_t [NUM_CORES-1:0] strobes
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int GROUP_W = WORD_W - 2;

  function automatic coreStrobe_t decodePort(logic sel, logic wr, logic [ADDR_W-1:0] addr);
    coreStrobe_t s;
    regOp_e      aliasOp;
    logic [GROUP_W-1:0] group;
    logic [1:0]  slot;
    logic        aligned;

    s       = '{outOp: OP_NONE, oeOp: OP_NONE, rdEn: 1'b0, rdSrc: SRC_ZERO};
    slot    = addr[3:2];
    group   = addr[ADDR_W-1:4];
    aligned = (addr[1:0] == 2'b00);

    case (slot)
      2'd0:    aliasOp = OP_WRITE;
      2'd1:    aliasOp = OP_SET;
      2'd2:    aliasOp = OP_CLEAR;
      default: aliasOp = OP_FLIP;
    endcase

    if (sel && !wr) begin
      s.rdEn = 1'b1;
      if (aligned) begin
        if (group == GROUP_W'(GROUP_OUT)) begin
          s.rdSrc = SRC_OUT;
        end else if (group == GROUP_W'(GROUP_OE)) begin
          s.rdSrc = SRC_OE;
        end else if (group == GROUP_W'(GROUP_MISC)) begin
          if (slot == 2'd0)      s.rdSrc = SRC_CORE_ID;
          else if (slot == 2'd1) s.rdSrc = SRC_PINS;
        end
      end
    end else if (sel && wr && aligned) begin
      if (group == GROUP_W'(GROUP_OUT))     s.outOp = aliasOp;
      else if (group == GROUP_W'(GROUP_OE)) s.oeOp  = aliasOp;
    end
    return s;
  endfunction

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
    always_comb begin
      strobes[c] = decodePort(busSel[c], busWr[c], busAddr[c*ADDR_W +: ADDR_W]);
    end
  end

endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int PIN_W       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  coreStrobe_t [NUM_CORES-1:0] strobes,
  input  logic [NUM_CORES*BUS_W-1:0]  busWdata,
  output logic [NUM_CORES*BUS_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]            padIn,
  output logic [PIN_W-1:0]            padOut,
  output logic [PIN_W-1:0]            padOe
);

  logic [PIN_W-1:0] outReg, oeReg;
  logic [PIN_W-1:0] outNext, oeNext;
  logic [PIN_W-1:0] syncQ [SYNC_STAGES];

  // Ordered composition: port 0 first, then each higher port on its result
  always_comb begin
    logic [BUS_W-1:0] outAcc, oeAcc;
    outAcc = BUS_W'(outReg);
    oeAcc  = BUS_W'(oeReg);
    for (int c = 0; c < NUM_CORES; c++) begin
      outAcc = applyOp(strobes[c].outOp, outAcc, busWdata[c*BUS_W +: BUS_W]);
      oeAcc  = applyOp(strobes[c].oeOp,  oeAcc,  busWdata[c*BUS_W +: BUS_W]);
    end
    outNext = outAcc[PIN_W-1:0];
    oeNext  = oeAcc[PIN_W-1:0];
  end

  if (PIN_W < BUS_W) begin : g_unused
    logic [NUM_CORES-1:0] unusedWdataHi;
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      assign unusedWdataHi[c] = ^busWdata[c*BUS_W+PIN_W +: BUS_W-PIN_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      oeReg  <= '0;
    end else begin
      outReg <= outNext;
      oeReg  <= oeNext;
    end
  end

  // Input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  // Per-port registered read data
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_read
    logic [BUS_W-1:0] rdMux;
    always_comb begin
      case (strobes[c].rdSrc)
        SRC_CORE_ID: rdMux = BUS_W'(c);
        SRC_PINS:    rdMux = BUS_W'(syncQ[SYNC_STAGES-1]);
        SRC_OUT:     rdMux = BUS_W'(outReg);
        SRC_OE:      rdMux = BUS_W'(oeReg);
        default:     rdMux = '0;
      endcase
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                busRdata[c*BUS_W +: BUS_W] <= '0;
      else if (strobes[c].rdEn) busRdata[c*BUS_W +: BUS_W] <= rdMux;
    end
  end

  // Pad drive, one slice per pin
  for (genvar p = 0; p < PIN_W; p++) begin : g_pad
    assign padOe[p]  = oeReg[p];
    assign padOut[p] = oeReg[p] ? outReg[p] : 1'b0;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int PIN_W     = 30,
  parameter int ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        busSel,
  input  logic [NUM_CORES-1:0]        busWr,
  input  logic [NUM_CORES*ADDR_W-1:0] busAddr,
  input  logic [NUM_CORES*BUS_W-1:0]  busWdata,
  output logic [NUM_CORES*BUS_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]            padIn,
  output logic [PIN_W-1:0]            padOut,
  output logic [PIN_W-1:0]            padOe
);

  coreStrobe_t [NUM_CORES-1:0] strobes;

  gpio_bank_ctrl #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W)
  ) ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  gpio_bank_dpath #(
    .NUM_CORES  (NUM_CORES),
    .PIN_W      (PIN_W),
    .SYNC_STAGES(2)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int PIN_W     = 30,
  parameter int ADDR_W    = 6
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_CORES-1:0]        busSel,
  input logic [NUM_CORES-1:0]        busWr,
  input logic [NUM_CORES*ADDR_W-1:0] busAddr,
  input logic [PIN_W-1:0]            wdata0,
  input logic [NUM_CORES*BUS_W-1:0]  busRdata,
  input logic [PIN_W-1:0]            padOut,
  input logic [PIN_W-1:0]            padOe
);

  logic [NUM_CORES-1:0] wrOut, wrOe, rdAny;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    logic [ADDR_W-1:0] a;
    assign a        = busAddr[c*ADDR_W +: ADDR_W];
    assign wrOut[c] = busSel[c] && busWr[c] && a >= ADDR_W'(8'h10) && a <= ADDR_W'(8'h1C);
    assign wrOe[c]  = busSel[c] && busWr[c] && a >= ADDR_W'(8'h20) && a <= ADDR_W'(8'h2C);
    assign rdAny[c] = busSel[c] && !busWr[c];

    // R5: core identifier follows the requesting port
    assert_core_id_R5: assert property (@(posedge clk) disable iff (!rstN)
      (rdAny[c] && a == '0) |=> busRdata[c*BUS_W +: BUS_W] == BUS_W'(c));

    // R10: read data holds between reads
    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      !rdAny[c] |=> $stable(busRdata[c*BUS_W +: BUS_W]));

    if (PIN_W < BUS_W) begin : g_hi
      // R2: unimplemented top bits read as zero
      assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
        busRdata[c*BUS_W+PIN_W +: BUS_W-PIN_W] == '0);
    end
  end

  logic [ADDR_W-1:0] addr0;
  logic lone0;
  assign addr0 = busAddr[ADDR_W-1:0];
  assign lone0 = busSel[0] && busWr[0] && ((wrOe & ~NUM_CORES'(1)) == '0);

  // R3: enable set alias forces written ones
  assert_oe_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lone0 && addr0 == ADDR_W'(8'h24)) |=> (padOe & $past(wdata0)) == $past(wdata0));

  // R4: enable clear alias drops written ones and keeps the rest
  assert_oe_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lone0 && addr0 == ADDR_W'(8'h28)) |=> padOe == ($past(padOe) & ~$past(wdata0)));

  // R4: enable toggle alias inverts written ones
  assert_oe_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lone0 && addr0 == ADDR_W'(8'h2C)) |=> padOe == ($past(padOe) ^ $past(wdata0)));

  // R11: pads change only through writes to the two registers
  assert_pads_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((wrOut | wrOe) == '0) |=> ($stable(padOe) && $stable(padOut)));

  // R9: an undriven pin never shows a driven 1
  assert_drive_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_CORES(NUM_CORES),
  .PIN_W    (PIN_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .wdata0  (busWdata[PIN_W-1:0]),
  .busRdata(busRdata),
  .padOut  (padOut),
  .padOe   (padOe)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int PW = 30;
  localparam int AW = 6;

  typedef struct packed {
    logic        core;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [0:12] = '{
    '{1'b0, 6'h10, 32'hFFFF_FFFF},
    '{1'b1, 6'h20, 32'h0000_FF0F},
    '{1'b0, 6'h18, 32'h0F0F_0F0F},
    '{1'b1, 6'h14, 32'h0000_0033},
    '{1'b0, 6'h1C, 32'h2AAA_5555},
    '{1'b1, 6'h24, 32'h3000_0000},
    '{1'b0, 6'h28, 32'h0000_000F},
    '{1'b1, 6'h2C, 32'hFFFF_0000},
    '{1'b0, 6'h08, 32'h1234_5678},
    '{1'b1, 6'h00, 32'hFFFF_FFFF},
    '{1'b0, 6'h04, 32'hFFFF_FFFF},
    '{1'b1, 6'h12, 32'h0000_0000},
    '{1'b0, 6'h30, 32'hFFFF_FFFF}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NC-1:0]  busSel = '0;
  logic [NC-1:0]  busWr = '0;
  logic [NC*AW-1:0] busAddr = '0;
  logic [NC*32-1:0] busWdata = '0;
  logic [NC*32-1:0] busRdata;
  logic [PW-1:0]  padIn = '0;
  logic [PW-1:0]  padOut, padOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [PW-1:0] mOut = '0;
  logic [PW-1:0] mOe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_CORES(NC), .PIN_W(PW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one register update, from the address map
  task automatic modelApply(input logic [5:0] a, input logic [31:0] d);
    case (a)
      6'h10: mOut = d[PW-1:0];
      6'h14: mOut = mOut | d[PW-1:0];
      6'h18: mOut = mOut & ~d[PW-1:0];
      6'h1C: mOut = mOut ^ d[PW-1:0];
      6'h20: mOe  = d[PW-1:0];
      6'h24: mOe  = mOe | d[PW-1:0];
      6'h28: mOe  = mOe & ~d[PW-1:0];
      6'h2C: mOe  = mOe ^ d[PW-1:0];
      default: ;
    endcase
  endtask

  function automatic string tagFor(input logic [5:0] a);
    case (a)
      6'h10, 6'h20: return "R2";
      6'h14, 6'h24: return "R3";
      6'h18, 6'h1C, 6'h28, 6'h2C: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic setPort(input int c, input logic wr, input logic [5:0] a, input logic [31:0] d);
    busSel[c] = 1'b1;
    busWr[c] = wr;
    busAddr[c*AW +: AW] = a;
    busWdata[c*32 +: 32] = d;
  endtask

  task automatic doWrite(input int c, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    setPort(c, 1'b1, a, d);
    @(negedge clk);
    busSel = '0;
  endtask

  task automatic doRead(input int c, input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    setPort(c, 1'b0, a, '0);
    @(negedge clk);
    busSel = '0;
    v = busRdata[c*32 +: 32];
  endtask

  task automatic checkState(input string tag);
    logic [31:0] v;
    doRead(0, 6'h10, v);
    check({tag, " output readback"}, v, {2'b00, mOut});
    doRead(1, 6'h20, v);
    check({tag, " enable readback"}, v, {2'b00, mOe});
    check({tag, " R9 padOut"}, {2'b00, padOut}, {2'b00, mOut & mOe});
    check({tag, " R9 padOe"}, {2'b00, padOe}, {2'b00, mOe});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v0, v1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 padOut", {2'b00, padOut}, '0);
    check("R1 padOe", {2'b00, padOe}, '0);
    check("R1 rdata0", busRdata[31:0], '0);
    check("R1 rdata1", busRdata[63:32], '0);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    // Vector walk: one update per entry, then readback and pad compare
    for (int i = 0; i <= 12; i++) begin
      doWrite(int'(VECS[i].core), VECS[i].addr, VECS[i].data);
      modelApply(VECS[i].addr, VECS[i].data);
      checkState($sformatf("%s vec%0d", tagFor(VECS[i].addr), i));
    end

    // R8: alias addresses read the underlying register
    doRead(0, 6'h14, v); check("R8 alias 0x14", v, {2'b00, mOut});
    doRead(1, 6'h18, v); check("R8 alias 0x18", v, {2'b00, mOut});
    doRead(0, 6'h1C, v); check("R8 alias 0x1C", v, {2'b00, mOut});
    doRead(1, 6'h24, v); check("R8 alias 0x24", v, {2'b00, mOe});
    doRead(0, 6'h28, v); check("R8 alias 0x28", v, {2'b00, mOe});
    doRead(1, 6'h2C, v); check("R8 alias 0x2C", v, {2'b00, mOe});

    // R5: core id per port, separately and together
    doRead(0, 6'h00, v); check("R5 core0 id", v, 32'd0);
    doRead(1, 6'h00, v); check("R5 core1 id", v, 32'd1);
    @(negedge clk);
    setPort(0, 1'b0, 6'h00, '0);
    setPort(1, 1'b0, 6'h00, '0);
    @(negedge clk);
    busSel = '0;
    check("R5 joint core0", busRdata[31:0], 32'd0);
    check("R5 joint core1", busRdata[63:32], 32'd1);

    // R10: unmapped and misaligned reads give zero, data holds after read
    doRead(0, 6'h08, v); check("R10 read 0x08", v, '0);
    doRead(1, 6'h0C, v); check("R10 read 0x0C", v, '0);
    doRead(0, 6'h3C, v); check("R10 read 0x3C", v, '0);
    doRead(1, 6'h11, v); check("R10 read 0x11", v, '0);
    doWrite(1, 6'h10, 32'h0000_0ABC);
    modelApply(6'h10, 32'h0000_0ABC);
    doRead(1, 6'h10, v);
    repeat (3) @(negedge clk);
    check("R10 hold after read", busRdata[63:32], 32'h0000_0ABC);

    // R10: read coinciding with a write sees the old value
    @(negedge clk);
    setPort(0, 1'b0, 6'h10, '0);
    setPort(1, 1'b1, 6'h10, 32'h0000_1234);
    @(negedge clk);
    busSel = '0;
    check("R10 read before write", busRdata[31:0], 32'h0000_0ABC);
    modelApply(6'h10, 32'h0000_1234);
    checkState("R10 after write");

    // R7: same-cycle composition, port 0 then port 1
    doWrite(0, 6'h10, 32'h0000_00FF);
    modelApply(6'h10, 32'h0000_00FF);
    @(negedge clk);
    setPort(0, 1'b1, 6'h14, 32'h0000_0F00);
    setPort(1, 1'b1, 6'h18, 32'h0000_0FF0);
    @(negedge clk);
    busSel = '0;
    modelApply(6'h14, 32'h0000_0F00);
    modelApply(6'h18, 32'h0000_0FF0);
    doRead(0, 6'h10, v);
    check("R7 set then clear", v, 32'h0000_000F);

    doWrite(0, 6'h10, 32'h0000_00FF);
    modelApply(6'h10, 32'h0000_00FF);
    @(negedge clk);
    setPort(0, 1'b1, 6'h18, 32'h0000_0FF0);
    setPort(1, 1'b1, 6'h14, 32'h0000_0F00);
    @(negedge clk);
    busSel = '0;
    doRead(1, 6'h10, v);
    check("R7 clear then set", v, 32'h0000_0F0F);
    mOut = 30'h0000_0F0F;

    @(negedge clk);
    setPort(0, 1'b1, 6'h20, 32'h0000_0001);
    setPort(1, 1'b1, 6'h2C, 32'h0000_0003);
    @(negedge clk);
    busSel = '0;
    modelApply(6'h20, 32'h0000_0001);
    modelApply(6'h2C, 32'h0000_0003);
    check("R7 write then toggle one edge", {2'b00, padOe}, 32'h0000_0002);

    @(negedge clk);
    setPort(0, 1'b1, 6'h14, 32'h0000_F000);
    setPort(1, 1'b1, 6'h20, 32'h0000_FFFF);
    @(negedge clk);
    busSel = '0;
    modelApply(6'h14, 32'h0000_F000);
    modelApply(6'h20, 32'h0000_FFFF);
    checkState("R7 different targets");

    // R9: disabled pins stay low whatever the output bits hold
    doWrite(1, 6'h20, 32'h0000_00F0);
    modelApply(6'h20, 32'h0000_00F0);
    doWrite(0, 6'h10, 32'h3FFF_FFFF);
    modelApply(6'h10, 32'h3FFF_FFFF);
    check("R9 gated drive", {2'b00, padOut}, 32'h0000_00F0);

    // R6: two-stage input latency
    doRead(0, 6'h04, v0);
    check("R6 initial pins", v0, '0);
    @(negedge clk);
    padIn = 30'h2ABC_DEF1;
    @(negedge clk);
    setPort(0, 1'b0, 6'h04, '0);
    @(negedge clk);
    check("R6 second edge old", busRdata[31:0], '0);
    @(negedge clk);
    busSel = '0;
    check("R6 third edge new", busRdata[31:0], 32'h2ABC_DEF1);
    doRead(1, 6'h04, v1);
    check("R6 core1 pins", v1, 32'h2ABC_DEF1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule